// File: doc/BRIEF.md
# Secure Memory Partition Ownership Tracker

This block holds the ownership, engagement and access-rights state of a set of secure memory partitions that several bus masters share. A master sends a request carrying an operation, a partition index, its own master identifier and a permission mask. The block answers one cycle later with a result code. A partition moves from free to owned when it is claimed, and from owned to engaged when its owner engages it with an initial set of rights. While it is engaged, its owner can narrow those rights but can never widen them. The owner can also hand the partition back.

The status outputs describe every partition at once. The owner word packs two bits per partition and is decoded from the point of view of a chosen viewer master, so the same partition reads as "mine" to its owner and as "someone else's" to every other master. The engaged word has one bit per partition. A permission read port shows the stored rights of one selected partition.

A fail pulse from the security monitor wipes every partition that has not set its keep-on-fail right. A wiped partition becomes free, is no longer engaged and loses all its rights. Partitions at or above a parameter count are not implemented and always report as unusable.

Top module: `part_own_tracker`

## Requirements
- R1: After reset, every implemented partition reads as free (code 0), every unimplemented one reads as unusable (code 1), the engaged word is all zero, every stored permission is zero and `rspValid` is low.
- R2: Bits [2i+1:2i] of `ownerWord` give partition i as seen by `viewMaster`: 0 = free, 1 = unusable, 2 = owned by a different master, 3 = owned by `viewMaster`. Bit i of `engagedWord` is set exactly when partition i is engaged.
- R3: A claim (op code 0) on a free partition returns OK (result 0) and leaves it owned by `reqMaster` and not engaged. A claim on an owned partition returns DENIED (result 1) and changes nothing.
- R4: An engage (op code 1) succeeds only when the requester owns the partition and it is not yet engaged. It sets the engaged bit and stores `reqPerm` AND 0xD0000F67, which keeps keep-on-fail (bit 28), host read/write/execute (bits 10/9/8), trusted-host read/write (bits 6/5), other-master read/write/execute (bits 2/1/0), bits 11, 31 and 30. Any other engage returns DENIED.
- R5: A narrow (op code 2) succeeds only for the owner of an engaged partition. It replaces the stored rights with their AND with the masked `reqPerm`, so a cleared right never comes back while the partition stays engaged. Any other narrow returns DENIED.
- R6: A hand-back (op code 3) by the owner returns OK and makes the partition free, not engaged and with zero rights. A hand-back by anyone else returns DENIED.
- R7: On a `failEvent` cycle, every implemented partition whose stored bit 28 is clear becomes free, not engaged and zero-rights, and the others keep their state. A request made in the same cycle returns DENIED and has no effect.
- R8: A request naming a partition at or above `NUM_USABLE` returns UNUSABLE (result 2) and changes no state.
- R9: `rspValid` and `rspCode` appear on the cycle after the request edge, with exactly one response per request. The status outputs reflect a request from that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqOp | input | 2 | 0 claim, 1 engage, 2 narrow, 3 hand back |
| reqPart | input | PART_W | Target partition index |
| reqMaster | input | MID_W | Requesting master identifier |
| reqPerm | input | 32 | Permission mask for engage or narrow |
| failEvent | input | 1 | Security monitor entered fail (one-cycle pulse) |
| viewMaster | input | MID_W | Master whose view `ownerWord` shows |
| permSel | input | PART_W | Partition whose rights appear on `permOut` |
| rspValid | output | 1 | Result valid |
| rspCode | output | 2 | 0 OK, 1 DENIED, 2 UNUSABLE |
| ownerWord | output | 2*NUM_PART | Packed owner codes |
| engagedWord | output | NUM_PART | Engaged bits |
| permOut | output | 32 | Stored rights of partition `permSel` |

## Verification
The result code is due one clock edge after the request is presented. The owner word, engaged word and stored rights change at that same edge. The owner word and the permission read port also follow `viewMaster` and `permSel` combinationally, with no latency. The bench drives each request just after a falling edge and updates its behavioural model for the coming rising edge. At the next falling edge it compares every output against the model, so every result is sampled in the cycle it is due and well away from the edge that produced it.

// File: rtl/part_own_pkg.sv
package part_own_pkg;

  typedef enum logic [1:0] {
    OP_CLAIM  = 2'd0,
    OP_ENGAGE = 2'd1,
    OP_NARROW = 2'd2,
    OP_FREE   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    RES_OK       = 2'd0,
    RES_DENIED   = 2'd1,
    RES_UNUSABLE = 2'd2
  } res_e;

  localparam logic [1:0] CODE_FREE     = 2'd0;
  localparam logic [1:0] CODE_UNUSABLE = 2'd1;
  localparam logic [1:0] CODE_OTHER    = 2'd2;
  localparam logic [1:0] CODE_SELF     = 2'd3;

  localparam logic [31:0] PERM_KEEP_MASK = 32'hD000_0F67;
  localparam int          KEEP_ON_FAIL   = 28;

  // strobes from control to the per-partition state
  typedef struct packed {
    logic claim;
    logic engage;
    logic narrow;
    logic freeUp;
    logic wipe;
  } strobe_t;

endpackage

// File: rtl/part_own_ctrl.sv
module part_own_ctrl
  import part_own_pkg::*;
#(
  parameter int NUM_PART   = 16,
  parameter int NUM_USABLE = 12,
  parameter int MID_W      = 4,
  parameter int PART_W     = $clog2(NUM_PART)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            reqValid,
  input  logic [1:0]                      reqOp,
  input  logic [PART_W-1:0]               reqPart,
  input  logic [MID_W-1:0]                reqMaster,
  input  logic                            failEvent,
  input  logic [NUM_PART-1:0]             ownValid,
  input  logic [NUM_PART-1:0][MID_W-1:0]  ownId,
  input  logic [NUM_PART-1:0]             engaged,
  output strobe_t                         strobes,
  output logic                            rspValid,
  output logic [1:0]                      rspCode
);

  logic inRange;
  logic isOwner;
  res_e verdict;

  assign inRange = (int'(reqPart) < NUM_USABLE);
  assign isOwner = ownValid[reqPart] && (ownId[reqPart] == reqMaster);

  always_comb begin
    strobes = '0;
    verdict = RES_DENIED;
    if (failEvent) begin
      strobes.wipe = 1'b1;
    end else if (reqValid) begin
      if (!inRange) begin
        verdict = RES_UNUSABLE;
      end else begin
        unique case (op_e'(reqOp))
          OP_CLAIM: if (!ownValid[reqPart]) begin
            strobes.claim = 1'b1;
            verdict = RES_OK;
          end
          OP_ENGAGE: if (isOwner && !engaged[reqPart]) begin
            strobes.engage = 1'b1;
            verdict = RES_OK;
          end
          OP_NARROW: if (isOwner && engaged[reqPart]) begin
            strobes.narrow = 1'b1;
            verdict = RES_OK;
          end
          OP_FREE: if (isOwner) begin
            strobes.freeUp = 1'b1;
            verdict = RES_OK;
          end
          default: verdict = RES_DENIED;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspCode  <= RES_OK;
    end else begin
      rspValid <= reqValid;
      rspCode  <= verdict;
    end
  end

  // R9: every request is answered on the next cycle
  a_r9_one_response: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  // R8: out-of-range partitions are reported unusable
  a_r8_unusable: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !failEvent && !inRange) |=> (rspCode == RES_UNUSABLE));
  // R4: a second engage of an engaged partition is refused
  a_r4_engage_twice: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && inRange && reqOp == OP_ENGAGE && engaged[reqPart]) |=> (rspCode == RES_DENIED));
  // R7: a request colliding with a fail pulse is refused
  a_r7_fail_denies: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && failEvent) |=> (rspCode == RES_DENIED));

endmodule

// File: rtl/part_own_dp.sv
module part_own_dp
  import part_own_pkg::*;
#(
  parameter int NUM_PART   = 16,
  parameter int NUM_USABLE = 12,
  parameter int MID_W      = 4,
  parameter int PART_W     = $clog2(NUM_PART)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  strobe_t                         strobes,
  input  logic [PART_W-1:0]               reqPart,
  input  logic [MID_W-1:0]                reqMaster,
  input  logic [31:0]                     reqPerm,
  input  logic [MID_W-1:0]                viewMaster,
  input  logic [PART_W-1:0]               permSel,
  output logic [NUM_PART-1:0]             ownValid,
  output logic [NUM_PART-1:0][MID_W-1:0]  ownId,
  output logic [NUM_PART-1:0]             engaged,
  output logic [2*NUM_PART-1:0]           ownerWord,
  output logic [NUM_PART-1:0]             engagedWord,
  output logic [31:0]                     permOut
);

  logic             ownValidQ [NUM_PART];
  logic [MID_W-1:0] ownIdQ    [NUM_PART];
  logic             engQ      [NUM_PART];
  logic [31:0]      permQ     [NUM_PART];
  logic [31:0]      maskedPerm;

  assign maskedPerm = reqPerm & PERM_KEEP_MASK;

  for (genvar i = 0; i < NUM_PART; i++) begin : g_slot
    if (i < NUM_USABLE) begin : g_live
      logic hit;
      assign hit = (int'(reqPart) == i);

      always_ff @(posedge clk) begin
        if (!rstN) begin
          ownValidQ[i] <= 1'b0;
          ownIdQ[i]    <= '0;
          engQ[i]      <= 1'b0;
          permQ[i]     <= '0;
        end else if (strobes.wipe) begin
          if (!permQ[i][KEEP_ON_FAIL]) begin
            ownValidQ[i] <= 1'b0;
            ownIdQ[i]    <= '0;
            engQ[i]      <= 1'b0;
            permQ[i]     <= '0;
          end
        end else if (hit) begin
          if (strobes.claim) begin
            ownValidQ[i] <= 1'b1;
            ownIdQ[i]    <= reqMaster;
            engQ[i]      <= 1'b0;
            permQ[i]     <= '0;
          end else if (strobes.engage) begin
            engQ[i]      <= 1'b1;
            permQ[i]     <= maskedPerm;
          end else if (strobes.narrow) begin
            permQ[i]     <= permQ[i] & maskedPerm;
          end else if (strobes.freeUp) begin
            ownValidQ[i] <= 1'b0;
            ownIdQ[i]    <= '0;
            engQ[i]      <= 1'b0;
            permQ[i]     <= '0;
          end
        end
      end

      assign ownerWord[2*i +: 2] = !ownValidQ[i]             ? CODE_FREE :
                                   (ownIdQ[i] == viewMaster) ? CODE_SELF : CODE_OTHER;

      // R2: an engaged partition always has an owner
      a_r2_engaged_owned: assert property (@(posedge clk) disable iff (!rstN)
        engQ[i] |-> ownValidQ[i]);
      // R5: rights never gain a bit while the engagement lasts
      a_r5_no_widen: assert property (@(posedge clk) disable iff (!rstN)
        (engQ[i] && $past(engQ[i])) |-> ((permQ[i] & ~$past(permQ[i])) == 32'd0));
      // R7: a fail pulse frees partitions without the keep-on-fail right
      a_r7_wipe_frees: assert property (@(posedge clk) disable iff (!rstN)
        (strobes.wipe && !permQ[i][KEEP_ON_FAIL]) |=> !ownValidQ[i]);
      // R7: a fail pulse spares partitions holding the keep-on-fail right
      a_r7_keep_stays: assert property (@(posedge clk) disable iff (!rstN)
        (strobes.wipe && permQ[i][KEEP_ON_FAIL]) |=> $stable(permQ[i]));
    end else begin : g_dead
      assign ownValidQ[i] = 1'b0;
      assign ownIdQ[i]    = '0;
      assign engQ[i]      = 1'b0;
      assign permQ[i]     = '0;
      assign ownerWord[2*i +: 2] = CODE_UNUSABLE;
    end

    assign ownValid[i]    = ownValidQ[i];
    assign ownId[i]       = ownIdQ[i];
    assign engaged[i]     = engQ[i];
    assign engagedWord[i] = engQ[i];
  end

  assign permOut = permQ[permSel];

endmodule

// File: rtl/part_own_tracker.sv
module part_own_tracker
  import part_own_pkg::*;
#(
  parameter int NUM_PART   = 16,
  parameter int NUM_USABLE = 12,
  parameter int MID_W      = 4,
  localparam int PART_W    = $clog2(NUM_PART)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [1:0]              reqOp,
  input  logic [PART_W-1:0]       reqPart,
  input  logic [MID_W-1:0]        reqMaster,
  input  logic [31:0]             reqPerm,
  input  logic                    failEvent,
  input  logic [MID_W-1:0]        viewMaster,
  input  logic [PART_W-1:0]       permSel,
  output logic                    rspValid,
  output logic [1:0]              rspCode,
  output logic [2*NUM_PART-1:0]   ownerWord,
  output logic [NUM_PART-1:0]     engagedWord,
  output logic [31:0]             permOut
);

  strobe_t                        strobes;
  logic [NUM_PART-1:0]            ownValid;
  logic [NUM_PART-1:0][MID_W-1:0] ownId;
  logic [NUM_PART-1:0]            engaged;

  part_own_ctrl #(
    .NUM_PART(NUM_PART), .NUM_USABLE(NUM_USABLE), .MID_W(MID_W), .PART_W(PART_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqPart(reqPart),
    .reqMaster(reqMaster), .failEvent(failEvent), .ownValid(ownValid), .ownId(ownId),
    .engaged(engaged), .strobes(strobes), .rspValid(rspValid), .rspCode(rspCode)
  );

  part_own_dp #(
    .NUM_PART(NUM_PART), .NUM_USABLE(NUM_USABLE), .MID_W(MID_W), .PART_W(PART_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqPart(reqPart), .reqMaster(reqMaster),
    .reqPerm(reqPerm), .viewMaster(viewMaster), .permSel(permSel), .ownValid(ownValid),
    .ownId(ownId), .engaged(engaged), .ownerWord(ownerWord), .engagedWord(engagedWord),
    .permOut(permOut)
  );

endmodule

// File: tb/tb_part_own_tracker.sv
`timescale 1ns/1ps
module tb_part_own_tracker;

  localparam int NP = 16;
  localparam int NU = 12;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [1:0]  reqOp;
  logic [3:0]  reqPart;
  logic [3:0]  reqMaster;
  logic [31:0] reqPerm;
  logic        failEvent;
  logic [3:0]  viewMaster;
  logic [3:0]  permSel;
  logic        rspValid;
  logic [1:0]  rspCode;
  logic [31:0] ownerWord;
  logic [15:0] engagedWord;
  logic [31:0] permOut;

  part_own_tracker #(.NUM_PART(NP), .NUM_USABLE(NU), .MID_W(4)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqPart(reqPart),
    .reqMaster(reqMaster), .reqPerm(reqPerm), .failEvent(failEvent),
    .viewMaster(viewMaster), .permSel(permSel), .rspValid(rspValid), .rspCode(rspCode),
    .ownerWord(ownerWord), .engagedWord(engagedWord), .permOut(permOut)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural model: owner id or -1 when free
  int          mOwn  [NP];
  bit          mEng  [NP];
  logic [31:0] mPerm [NP];
  bit          expValid;
  int          expCode;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expOwners(int view);
    logic [31:0] w = '0;
    for (int i = 0; i < NP; i++) begin
      if (i >= NU)              w[2*i +: 2] = 2'd1;
      else if (mOwn[i] < 0)     w[2*i +: 2] = 2'd0;
      else if (mOwn[i] == view) w[2*i +: 2] = 2'd3;
      else                      w[2*i +: 2] = 2'd2;
    end
    return w;
  endfunction

  function automatic logic [15:0] expEng();
    logic [15:0] e = '0;
    for (int i = 0; i < NP; i++) e[i] = mEng[i];
    return e;
  endfunction

  task automatic clearSlot(int p);
    mOwn[p] = -1; mEng[p] = 0; mPerm[p] = '0;
  endtask

  // one request cycle: drive, update the model, compare at the next falling edge
  task automatic apply(bit v, int op, int p, int m, logic [31:0] perm, bit f, int view, int ps);
    string tag;
    logic [31:0] mk;
    reqValid = v; reqOp = 2'(op); reqPart = 4'(p); reqMaster = 4'(m);
    reqPerm = perm; failEvent = f; viewMaster = 4'(view); permSel = 4'(ps);
    mk = perm & 32'hD000_0F67;
    expValid = v;
    expCode  = 1;
    tag = (op == 0) ? "R3" : (op == 1) ? "R4" : (op == 2) ? "R5" : "R6";
    if (f) begin
      tag = "R7";
      for (int i = 0; i < NU; i++) if (!mPerm[i][28]) clearSlot(i);
    end else if (v) begin
      if (p >= NU) begin
        tag = "R8"; expCode = 2;
      end else begin
        case (op)
          0: if (mOwn[p] < 0) begin mOwn[p] = m; mEng[p] = 0; mPerm[p] = '0; expCode = 0; end
          1: if (mOwn[p] == m && !mEng[p]) begin mEng[p] = 1; mPerm[p] = mk; expCode = 0; end
          2: if (mOwn[p] == m && mEng[p]) begin mPerm[p] = mPerm[p] & mk; expCode = 0; end
          default: if (mOwn[p] == m) begin clearSlot(p); expCode = 0; end
        endcase
      end
    end
    @(negedge clk);
    chk("R9 rspValid", 64'(rspValid), 64'(expValid));
    if (expValid) chk({tag, " rspCode"}, 64'(rspCode), 64'(expCode));
    chk({tag, " R2 ownerWord"}, 64'(ownerWord), 64'(expOwners(view)));
    chk({tag, " R2 engagedWord"}, 64'(engagedWord), 64'(expEng()));
    chk({tag, " R5 permOut"}, 64'(permOut), 64'((ps < NU) ? mPerm[ps] : 32'd0));
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NP; i++) clearSlot(i);
    rstN = 1'b0; reqValid = 0; reqOp = 0; reqPart = 0; reqMaster = 0;
    reqPerm = 0; failEvent = 0; viewMaster = 0; permSel = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rspValid", 64'(rspValid), 64'd0);
    chk("R1 ownerWord", 64'(ownerWord), 64'h5500_0000);
    chk("R1 engagedWord", 64'(engagedWord), 64'd0);
    chk("R1 permOut", 64'(permOut), 64'd0);

    apply(1, 0, 0, 1, 0, 0, 1, 0);               // R3 claim ok
    apply(1, 0, 0, 2, 0, 0, 2, 0);               // R3 claim denied, viewer sees other
    apply(1, 1, 0, 2, 32'hFFFF_FFFF, 0, 1, 0);   // R4 non-owner engage denied
    apply(1, 1, 0, 1, 32'hFFFF_FFFF, 0, 1, 0);   // R4 masked rights D0000F67
    apply(1, 1, 0, 1, 32'hFFFF_FFFF, 0, 1, 0);   // R4 second engage denied
    apply(1, 2, 0, 2, 32'h0, 0, 1, 0);           // R5 non-owner narrow denied
    apply(1, 2, 0, 1, 32'h0000_0F00, 0, 1, 0);   // R5 narrow to host rights
    apply(1, 2, 0, 1, 32'hFFFF_FFFF, 0, 1, 0);   // R5 cannot widen again
    apply(1, 0, 1, 2, 0, 0, 2, 1);
    apply(1, 1, 1, 2, 32'h1000_0067, 0, 2, 1);   // keep-on-fail
    apply(1, 0, 2, 3, 0, 0, 3, 2);
    apply(1, 1, 2, 3, 32'h0000_0067, 0, 3, 2);
    apply(1, 0, 3, 1, 0, 0, 1, 3);
    apply(1, 2, 3, 1, 32'hF, 0, 1, 3);           // R5 narrow on unengaged denied
    apply(1, 3, 1, 1, 0, 0, 5, 1);               // R6 non-owner hand-back denied
    apply(1, 3, 3, 1, 0, 0, 1, 3);               // R6 owner hand-back
    apply(1, 2, 3, 1, 0, 0, 1, 3);               // R5 narrow on free denied
    apply(1, 0, 12, 1, 0, 0, 1, 12);             // R8 boundary
    apply(1, 3, 15, 1, 0, 0, 1, 15);             // R8 top index
    apply(0, 0, 0, 0, 0, 0, 2, 0);               // R9 idle
    apply(1, 0, 4, 5, 0, 0, 5, 4);
    apply(1, 0, 5, 5, 0, 1, 5, 1);               // R7 fail with colliding claim
    apply(1, 0, 0, 3, 0, 0, 3, 0);               // R3 wiped slot reclaimed

    for (int n = 0; n < 3000; n++) begin
      int op = int'($urandom_range(0, 3));
      int p  = int'($urandom_range(0, 15));
      int m  = int'($urandom_range(0, 3));
      int vw = int'($urandom_range(0, 3));
      int ps = int'($urandom_range(0, 15));
      bit v  = ($urandom_range(0, 7) != 0);
      bit f  = ($urandom_range(0, 59) == 0);
      apply(v, op, p, m, $urandom(), f, vw, ps);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule